// File: doc/BRIEF.md
# Ring-Buffer Byte Reader

This block drains a ring region of a wide memory and hands it to a narrow consumer. It walks a private beat address from a programmable first address to a programmable last address and then back again, issues one 64-bit read per step to a memory-controller read port, keeps the returned beats in a four-entry return queue, and splits every beat into eight bytes that leave through a valid/ready stream. The address only ever steps by one beat, so no address arithmetic is done per access.

A companion writer publishes how many beats it has stored (`wr_count_i`). This reader counts the beats it has requested and requests another only while the writer is strictly ahead of it. Unwritten or stale locations are therefore never fetched. Both counts are wider than the address, so a reader that trails by a full lap of the ring is not mistaken for one that has caught up. Several copies with different first addresses can read one written region in parallel, for example one copy per image row of a neighbourhood filter.

Top module: `rb_byte_reader`

## Requirements
- R1: While rst_ni is low, and in the first cycle after release with `wr_count_i` at 0, `rd_req_o` is 0, `out_valid_o` is 0 and `rd_addr_o` equals `first_addr_i`.
- R2: The number of beats requested since reset never exceeds the writer count. Both counts are taken modulo 2^CNT_W, and the writer may lead by less than 2^(CNT_W-1). When the writer count moves ahead by k, exactly k more beats are requested.
- R3: The requested beats that have not yet been moved into the unpacking register never number more than the return depth (4). With the output stalled and the writer well ahead, exactly DEPTH+1 beats are requested and `rd_req_o` then stays low.
- R4: The n-th request (counting from 0 after reset) uses address first + (n mod (last-first+1)). The address steps to `first_addr_i` after a request at `last_addr_i`. This assumes first ≤ last.
- R5: Each beat leaves as eight bytes, bits [7:0] first and bits [63:56] last. Beats leave in the order they were requested.
- R6: A byte is consumed only in a cycle where `out_valid_o` and `out_ready_i` are both high. While valid is high and ready is low, `out_valid_o` stays high and `out_data_o` does not change. No byte is lost or repeated.
- R7: An asynchronous reset during streaming drops buffered and partly unpacked data. After the reset, requests and bytes start again from `first_addr_i` and byte 0.
- R8: A request that sees `rd_gnt_i` low stays asserted with the same address until it is granted. This holds as long as `wr_count_i` does not move backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| first_addr_i | input | ADDR_W | First beat address of the ring |
| last_addr_i | input | ADDR_W | Last beat address of the ring |
| wr_count_i | input | CNT_W | Beats stored so far by the companion writer |
| rd_req_o | output | 1 | Read request to memory controller |
| rd_addr_o | output | ADDR_W | Beat address of the request |
| rd_gnt_i | input | 1 | Request accepted this cycle |
| rd_rvalid_i | input | 1 | Read data returned this cycle |
| rd_rdata_i | input | BEAT_W | Returned beat |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | LANE_W | Output byte |
| out_ready_i | input | 1 | Consumer accepts byte |

## Verification
A wrong beat count shows up in one of two ways: requests that run past the writer, or a stream that stops short of the writer. Either is visible within a few cycles of a `wr_count_i` change. A broken address counter puts a wrong `rd_addr_o` on the very next request, and at the latest on the request that follows a visit to the last address. A wrong byte index or a bad queue pointer corrupts or reorders `out_data_o` within one beat of eight bytes. A credit that is not returned makes the count of requested beats under a stalled consumer differ from DEPTH+1.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  localparam int unsigned BEAT_W_DEF = 64;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned RET_DEPTH_DEF = 4;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/rbr_addr_walk.sv
module rbr_addr_walk #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  // offset from first address, so reset needs no load of an input
  logic [ADDR_W-1:0] off_q;
  logic              at_last;

  assign addr_o  = first_i + off_q;
  assign at_last = (addr_o == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      off_q <= '0;
    else if (step_i)  off_q <= at_last ? '0 : off_q + 1'b1;
  end

  p_addr_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_i <= last_i) |-> (addr_o >= first_i && addr_o <= last_i));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && addr_o == last_i && $stable(first_i)) |=> (addr_o == $past(first_i)));
endmodule

// File: rtl/rbr_ret_queue.sv
module rbr_ret_queue #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = rbr_pkg::clog2_min1(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             nonempty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdata_o    = mem_q[rp_q];
  assign nonempty_o = (cnt_q != '0);
  assign count_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q != CNT_W'(DEPTH)));

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> nonempty_o);
endmodule

// File: rtl/rbr_unpack.sv
module rbr_unpack #(
  parameter int unsigned BEAT_W = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = BEAT_W / LANE_W,
  localparam int unsigned IDX_W = rbr_pkg::clog2_min1(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_avail_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic              beat_take_o,
  output logic              out_valid_o,
  output logic [LANE_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  logic [BEAT_W-1:0] beat_q;
  logic              hold_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LANE_W-1:0] lane_w [LANES];
  logic              consume, last_lane, free;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = beat_q[g*LANE_W +: LANE_W];
  end

  assign last_lane   = (idx_q == IDX_W'(LANES - 1));
  assign consume     = hold_q & out_ready_i;
  assign free        = !hold_q | (consume & last_lane);
  assign beat_take_o = free & beat_avail_i;
  assign out_valid_o = hold_q;
  assign out_data_o  = lane_w[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      hold_q <= 1'b0;
      idx_q  <= '0;
    end else if (beat_take_o) begin
      beat_q <= beat_i;
      hold_q <= 1'b1;
      idx_q  <= '0;
    end else if (consume && last_lane) begin
      hold_q <= 1'b0;
      idx_q  <= '0;
    end else if (consume) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_idx_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_take_o |=> (idx_q == '0));
endmodule

// File: rtl/rb_byte_reader.sv
module rb_byte_reader #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CNT_W     = 18,
  parameter int unsigned BEAT_W    = rbr_pkg::BEAT_W_DEF,
  parameter int unsigned LANE_W    = rbr_pkg::LANE_W_DEF,
  parameter int unsigned RET_DEPTH = rbr_pkg::RET_DEPTH_DEF,
  localparam int unsigned CRED_W   = $clog2(RET_DEPTH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [CNT_W-1:0]  wr_count_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_rvalid_i,
  input  logic [BEAT_W-1:0] rd_rdata_i,
  output logic              out_valid_o,
  output logic [LANE_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  localparam int unsigned QCNT_W = $clog2(RET_DEPTH + 1);

  logic [CNT_W-1:0]  rd_count_q;
  logic [CNT_W-1:0]  lead;
  logic [CRED_W-1:0] used_q;
  logic              writer_ahead, has_credit, issue;
  logic              q_nonempty, q_pop;
  logic [BEAT_W-1:0] q_head;
  logic [QCNT_W-1:0] q_count;

  // modular lead: nonzero and not negative
  assign lead         = wr_count_i - rd_count_q;
  assign writer_ahead = (lead != '0) && !lead[CNT_W-1];
  assign has_credit   = (used_q < CRED_W'(RET_DEPTH));
  assign rd_req_o     = writer_ahead & has_credit;
  assign issue        = rd_req_o & rd_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_count_q <= '0;
      used_q     <= '0;
    end else begin
      if (issue) rd_count_q <= rd_count_q + 1'b1;
      case ({issue, q_pop})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  rbr_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_i (first_addr_i),
    .last_i  (last_addr_i),
    .step_i  (issue),
    .addr_o  (rd_addr_o)
  );

  rbr_ret_queue #(.WIDTH(BEAT_W), .DEPTH(RET_DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rd_rvalid_i),
    .wdata_i    (rd_rdata_i),
    .pop_i      (q_pop),
    .rdata_o    (q_head),
    .nonempty_o (q_nonempty),
    .count_o    (q_count)
  );

  rbr_unpack #(.BEAT_W(BEAT_W), .LANE_W(LANE_W)) u_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_avail_i (q_nonempty),
    .beat_i       (q_head),
    .beat_take_o  (q_pop),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_ready_i  (out_ready_i)
  );

  p_credit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q <= CRED_W'(RET_DEPTH)) && (CRED_W'(q_count) <= used_q));

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_gnt_i && $stable(first_addr_i)) |=> (rd_req_o && $stable(rd_addr_o)));

  p_no_stray_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rvalid_i |-> (used_q > CRED_W'(q_count)));
endmodule

// File: tb/rb_byte_reader_bench.sv
`timescale 1ns/1ps
module rb_byte_reader_bench;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 5;
  localparam int DEPTH  = 4;
  localparam logic [ADDR_W-1:0] FIRST = 4'd3;
  localparam logic [ADDR_W-1:0] LAST  = 4'd9;
  localparam int SPAN = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] wr_count_i = '0;
  logic rd_req_o, rd_gnt_i, rd_rvalid_i, out_valid_o, out_ready_i;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [63:0] rd_rdata_i;
  logic [7:0] out_data_o;

  int checks = 0, fails = 0;
  int issued_n = 0, byte_n = 0, cyc = 0;
  int gnt_mode = 0, rdy_mode = 1;
  logic pv [3];
  logic [ADDR_W-1:0] pa [3];
  logic prev_wait;
  logic [ADDR_W-1:0] prev_addr;
  logic prev_hold;
  logic [7:0] prev_byte;

  always #2.5 clk_i = ~clk_i;

  rb_byte_reader #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RET_DEPTH(DEPTH)) u_rb_byte_reader (
    .clk_i(clk_i), .rst_ni(rst_ni), .first_addr_i(FIRST), .last_addr_i(LAST),
    .wr_count_i(wr_count_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_gnt_i(rd_gnt_i), .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  function automatic logic [7:0] byte_of(input int a, input int k);
    return 8'((a * 29 + k * 13 + 8'h5A) & 8'hFF);
  endfunction

  function automatic logic [63:0] beat_of(input int a);
    logic [63:0] b;
    for (int k = 0; k < 8; k++) b[k*8 +: 8] = byte_of(a, k);
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // memory model, stimulus modes and stream monitor
  initial begin
    rd_gnt_i = 1'b1; out_ready_i = 1'b0; rd_rvalid_i = 1'b0; rd_rdata_i = '0;
    prev_wait = 1'b0; prev_hold = 1'b0; prev_addr = '0; prev_byte = '0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pa[i] = '0; end
    forever begin
      @(negedge clk_i);
      cyc++;
      if (!rst_ni) begin
        for (int i = 0; i < 3; i++) pv[i] = 1'b0;
        rd_rvalid_i = 1'b0; issued_n = 0; byte_n = 0;
        prev_wait = 1'b0; prev_hold = 1'b0;
        continue;
      end
      rd_gnt_i    = (gnt_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      out_ready_i = (rdy_mode == 0) ? 1'b0 : (rdy_mode == 1) ? 1'b1 : ((cyc % 4) < 2);
      #1;
      // R8: an ungranted request is held with its address
      if (prev_wait) chk(rd_req_o && rd_addr_o == prev_addr, "R8", int'(rd_addr_o), int'(prev_addr));
      // R6: stalled byte held
      if (prev_hold) chk(out_valid_o && out_data_o == prev_byte, "R6", int'(out_data_o), int'(prev_byte));
      prev_wait = rd_req_o && !rd_gnt_i;
      prev_addr = rd_addr_o;
      prev_hold = out_valid_o && !out_ready_i;
      prev_byte = out_data_o;
      // response pipe shift
      rd_rvalid_i = pv[2];
      rd_rdata_i  = beat_of(int'(pa[2]));
      pv[2] = pv[1]; pa[2] = pa[1];
      pv[1] = pv[0]; pa[1] = pa[0];
      pv[0] = 1'b0;
      if (rd_req_o && rd_gnt_i) begin
        chk(int'(rd_addr_o) == int'(FIRST) + issued_n % SPAN, "R4",
            int'(rd_addr_o), int'(FIRST) + issued_n % SPAN);
        pv[0] = 1'b1; pa[0] = rd_addr_o;
        issued_n++;
      end
      if (out_valid_o && out_ready_i) begin
        chk(out_data_o == byte_of(int'(FIRST) + (byte_n / 8) % SPAN, byte_n % 8), "R5",
            int'(out_data_o), int'(byte_of(int'(FIRST) + (byte_n / 8) % SPAN, byte_n % 8)));
        byte_n++;
      end
    end
  end

  initial begin
    #(150000 * 5);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  task automatic wait_bytes(input int target);
    for (int i = 0; i < 4000 && byte_n < target; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    wr_count_i = '0;
    rst_ni = 1'b0;
    #1;
    chk(!rd_req_o && !out_valid_o && rd_addr_o == FIRST, "R1", int'(rd_addr_o), int'(FIRST));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(!rd_req_o && !out_valid_o && rd_addr_o == FIRST, "R1", int'({rd_req_o, out_valid_o}), 0);
  endtask

  initial begin
    // R2: requests track writer lead exactly
    do_reset();
    gnt_mode = 0; rdy_mode = 1;
    @(negedge clk_i); wr_count_i = 5'd2;
    repeat (40) @(negedge clk_i);
    chk(issued_n == 2, "R2", issued_n, 2);
    chk(byte_n == 16, "R5", byte_n, 16);
    wr_count_i = 5'd3;
    repeat (40) @(negedge clk_i);
    chk(issued_n == 3, "R2", issued_n, 3);
    chk(byte_n == 24 && !out_valid_o, "R6", byte_n, 24);

    // R3: stalled output bounds requests to DEPTH+1
    do_reset();
    rdy_mode = 0;
    @(negedge clk_i); wr_count_i = 5'd12;
    repeat (60) @(negedge clk_i);
    chk(issued_n == DEPTH + 1, "R3", issued_n, DEPTH + 1);
    chk(!rd_req_o, "R3", int'(rd_req_o), 0);
    chk(byte_n == 0 && out_valid_o, "R6", byte_n, 0);
    rdy_mode = 1;
    wait_bytes(96);
    repeat (20) @(negedge clk_i);
    chk(issued_n == 12 && byte_n == 96, "R3", byte_n, 96);

    // R2/R4/R6/R8: counter wrap, ring wrap, ready and grant gaps
    gnt_mode = 1; rdy_mode = 2;
    for (int t = 22; t <= 42; t += 10) begin
      @(negedge clk_i); wr_count_i = CNT_W'(t);
      wait_bytes(t * 8);
      repeat (30) @(negedge clk_i);
      chk(issued_n == t, "R2", issued_n, t);
      chk(byte_n == t * 8, "R6", byte_n, t * 8);
    end

    // R7: reset mid-stream restarts at first address
    @(negedge clk_i); wr_count_i = CNT_W'(42 + 10);
    wait_bytes(42 * 8 + 13);
    do_reset();
    gnt_mode = 0; rdy_mode = 1;
    @(negedge clk_i); wr_count_i = 5'd2;
    repeat (40) @(negedge clk_i);
    chk(issued_n == 2 && byte_n == 16, "R7", byte_n, 16);

    summary();
  end
endmodule